// File: doc/BRIEF.md
# Register-addressed I2C master with internal repeated start

This block is a bus master for a two-wire serial bus. It runs a whole register-addressed transfer by itself once it takes a command. It creates the opening start condition, the repeated start and the closing stop condition internally, so no helper logic outside the block has to begin or end a transfer. The pad side is split into two parts. The block reads the resolved line levels on `scl_in` and `sda_in`. It pulls a line low with `scl_oe` or `sda_oe`. A line is never driven high: when the block lets go of a line, the external pull-up brings it high. A tristate pad at chip level, or a wired-AND with a pull-up in a bench, completes the bus.

Each command gives a 7-bit device address, a register address, a direction flag and `DATA_BYTES` bytes of write data.
- A write sends the device address, the register address and then the data bytes.
- A read sends the device address and the register address, then issues a repeated start, sends the device address again with the read flag, and receives `DATA_BYTES` bytes.

After the stop condition the block pulses `done` for one cycle. With that pulse it presents the read bytes and a flag that reports a refused acknowledge.

Top module: `i2c_regxfer_master`

## Requirements
- R1: After reset, and whenever no transfer is running, `scl_oe` and `sda_oe` are both 0, so both lines are released high. `done` is 0 except for its single pulse.
- R2: Every bit lasts four quarters of `QUARTER_CYCLES` clocks each. SCL is pulled low in quarters 0 and 3 and released in quarters 1 and 2. SDA changes only at the start of quarter 0, while SCL is low. SDA is sampled at the end of quarter 1, in the middle of the SCL-high time.
- R3: A start condition takes four quarters after the command is accepted. The SDA/SCL pull values are released/released, then SDA pulled with SCL released (this is the start condition), then the same again, then both pulled.
- R4: SDA changes while SCL stays released only for a start condition or a repeated start (SDA falls) and for a stop condition (SDA rises). The stop condition takes four quarters: both pulled, then SCL released with SDA pulled, then both released for two quarters.
- R5: Bytes are sent MSB first. An address byte is the 7-bit device address followed by a direction bit, where 0 means write and 1 means read. `sda_oe`=1 sends a 0.
- R6: When `cmd_rd`=0, the block sends a start, the address with the write bit, the register byte, then the data bytes (byte k is `cmd_wdata[8k+7:8k]`, lowest k first), then a stop. There is no repeated start.
- R7: When `cmd_rd`=1, the block sends a start, the address with the write bit, the register byte, a repeated start, the address with the read bit, then reads `DATA_BYTES` bytes, then sends a stop. A repeated start is: SCL pulled with SDA released, then both released, then SDA pulled with SCL released, then both pulled.
- R8: During read bytes the block releases SDA for the eight data bits. In the ninth bit it sends an acknowledge (SDA pulled low) for every byte except the last; for the last byte it releases SDA. Byte k received appears at `rd_data[8k+7:8k]`, with the first byte received at k=0.
- R9: After each byte the block sends, it releases SDA for a ninth bit. If the line reads high there, the block moves straight to a stop condition and ends with `nack_err`=1.
- R10: `done` is high for exactly one cycle. It rises in the cycle after the last stop quarter. `nack_err` and `rd_data` are valid from that cycle and hold until the next command is accepted, which clears `nack_err`.
- R11: `cmd_valid` is accepted only while no transfer is running. Command inputs that change during a transfer do not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Starts a transfer when the block is idle |
| cmd_dev | input | 7 | Device address |
| cmd_reg | input | 8 | Register address |
| cmd_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_wdata | input | 8*DATA_BYTES | Write bytes, byte 0 sent first |
| rd_data | output | 8*DATA_BYTES | Read bytes, byte 0 received first |
| done | output | 1 | One-cycle pulse when the bus is idle again |
| nack_err | output | 1 | A sent byte was not acknowledged |
| scl_in | input | 1 | Resolved clock line level |
| sda_in | input | 1 | Resolved data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The edge that accepts a command starts quarter 0. Quarter q therefore covers cycles q*QUARTER_CYCLES to (q+1)*QUARTER_CYCLES-1 after that edge, and `done` is due in cycle T*QUARTER_CYCLES, where T is the number of quarters in the transfer. The bench works out the quarter sequence for each command from the requirements, including the replies of a modelled target that pulls SDA for acknowledges and read bits. It compares `scl_oe`, `sda_oe` and `done` against that sequence at every falling clock edge. It then reads `done`, `nack_err` and `rd_data` in cycle T*QUARTER_CYCLES and in the cycle after it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    SEG_IDLE, SEG_START, SEG_ADW, SEG_REG, SEG_RST,
    SEG_ADR, SEG_WDAT, SEG_RDAT, SEG_STOP
  } seg_e;

  // Address byte: 7-bit device address, then direction (1 = read).
  function automatic logic [7:0] addr_byte(logic [6:0] dev, logic rd);
    return {dev, rd};
  endfunction

  // Pull-low pattern {scl_low, sda_low} for a segment, quarter and bit.
  function automatic logic [1:0] bus_drive(seg_e seg, logic [1:0] ph,
                                           logic [3:0] bitn, logic txbit,
                                           logic mack);
    logic [1:0] r;
    r = 2'b00;
    case (seg)
      SEG_IDLE:  r = 2'b00;
      SEG_START: r = (ph == 2'd0) ? 2'b00 : (ph == 2'd3) ? 2'b11 : 2'b01;
      SEG_RST:   r = (ph == 2'd0) ? 2'b10 : (ph == 2'd1) ? 2'b00 :
                     (ph == 2'd2) ? 2'b01 : 2'b11;
      SEG_STOP:  r = (ph == 2'd0) ? 2'b11 : (ph == 2'd1) ? 2'b01 : 2'b00;
      default: begin
        r[1] = (ph == 2'd0) || (ph == 2'd3);
        if (bitn == 4'd8) r[0] = (seg == SEG_RDAT) ? mack : 1'b0;
        else              r[0] = (seg == SEG_RDAT) ? 1'b0 : ~txbit;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QC = 4,
  localparam int CW = (QC > 1) ? $clog2(QC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(QC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int NB = 2,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [6:0]    cmd_dev,
  input  logic [7:0]    cmd_reg,
  input  logic          cmd_rd,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          scl_in,
  input  logic          sda_in,
  output seg_e          seg,
  output logic [1:0]    phase,
  output logic [3:0]    bitn,
  output logic          txbit,
  output logic          mack,
  output logic          accept,
  output logic          idle,
  output logic          done,
  output logic          nack,
  output logic [DW-1:0] rdata
);
  logic [IW-1:0] idx;
  logic [6:0]    dev_q;
  logic [7:0]    reg_q;
  logic          rd_q;
  logic [DW-1:0] wdata_q;
  logic          ack_low_q;
  logic [7:0]    cur_byte;
  logic          last, wtype, got_nack, sample_ev;
  seg_e          next_seg;
  logic [IW-1:0] next_idx;

  assign idle      = (seg == SEG_IDLE);
  assign accept    = idle && cmd_valid;
  assign last      = (idx == IW'(NB - 1));
  assign mack      = !last;
  assign sample_ev = !idle && tick && (phase == 2'd1) && scl_in;
  assign wtype     = (seg == SEG_ADW) || (seg == SEG_REG) ||
                     (seg == SEG_ADR) || (seg == SEG_WDAT);
  assign got_nack  = wtype && !ack_low_q;

  always_comb begin
    case (seg)
      SEG_ADW:  cur_byte = addr_byte(dev_q, 1'b0);
      SEG_ADR:  cur_byte = addr_byte(dev_q, 1'b1);
      SEG_REG:  cur_byte = reg_q;
      SEG_WDAT: cur_byte = wdata_q[{idx, 3'b000} +: 8];
      default:  cur_byte = 8'h00;
    endcase
  end
  assign txbit = cur_byte[~bitn[2:0]];

  always_comb begin
    next_idx = '0;
    if (got_nack) next_seg = SEG_STOP;
    else begin
      case (seg)
        SEG_ADW:  next_seg = SEG_REG;
        SEG_REG:  next_seg = rd_q ? SEG_RST : SEG_WDAT;
        SEG_ADR:  next_seg = SEG_RDAT;
        SEG_WDAT: next_seg = last ? SEG_STOP : SEG_WDAT;
        SEG_RDAT: next_seg = last ? SEG_STOP : SEG_RDAT;
        default:  next_seg = SEG_STOP;
      endcase
      if ((seg == SEG_WDAT || seg == SEG_RDAT) && !last) next_idx = idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_IDLE; phase <= '0; bitn <= '0; idx <= '0;
      dev_q <= '0; reg_q <= '0; rd_q <= 1'b0; wdata_q <= '0;
      rdata <= '0; nack <= 1'b0; done <= 1'b0; ack_low_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        seg <= SEG_START; phase <= '0; bitn <= '0; idx <= '0;
        dev_q <= cmd_dev; reg_q <= cmd_reg; rd_q <= cmd_rd;
        wdata_q <= cmd_wdata; nack <= 1'b0; ack_low_q <= 1'b0;
      end else if (!idle && tick) begin
        phase <= phase + 2'd1;
        if (sample_ev && bitn == 4'd8) ack_low_q <= ~sda_in;
        if (sample_ev && seg == SEG_RDAT && bitn != 4'd8)
          rdata[{idx, ~bitn[2:0]}] <= sda_in;
        if (phase == 2'd3) begin
          ack_low_q <= 1'b0;
          case (seg)
            SEG_START: seg <= SEG_ADW;
            SEG_RST:   seg <= SEG_ADR;
            SEG_STOP:  begin seg <= SEG_IDLE; done <= 1'b1; end
            default: begin
              if (bitn != 4'd8) bitn <= bitn + 4'd1;
              else begin
                bitn <= '0;
                seg  <= next_seg;
                idx  <= next_idx;
                if (got_nack) nack <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_pads.sv
module i2cm_pads
  import i2cm_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] phase,
  input  logic [3:0] bitn,
  input  logic       txbit,
  input  logic       mack,
  output logic       scl_oe,
  output logic       sda_oe
);
  assign {scl_oe, sda_oe} = bus_drive(seg, phase, bitn, txbit, mack);
endmodule

// File: rtl/i2c_regxfer_master.sv
module i2c_regxfer_master
  import i2cm_pkg::*;
#(
  parameter int QUARTER_CYCLES = 4,
  parameter int DATA_BYTES     = 2,
  localparam int DW = 8 * DATA_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [6:0]    cmd_dev,
  input  logic [7:0]    cmd_reg,
  input  logic          cmd_rd,
  input  logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          nack_err,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  seg_e       seg;
  logic [1:0] phase;
  logic [3:0] bitn;
  logic       txbit, mack;
  logic       q_tick, accept, idle;
  logic       start_win, stop_win;

  assign start_win = (seg == SEG_START) || (seg == SEG_RST);
  assign stop_win  = (seg == SEG_STOP);

  i2cm_qtick #(.QC(QUARTER_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(q_tick)
  );

  i2cm_seq #(.NB(DATA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(q_tick), .cmd_valid(cmd_valid),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_rd(cmd_rd),
    .cmd_wdata(cmd_wdata), .scl_in(scl_in), .sda_in(sda_in),
    .seg(seg), .phase(phase), .bitn(bitn), .txbit(txbit), .mack(mack),
    .accept(accept), .idle(idle), .done(done), .nack(nack_err),
    .rdata(rd_data)
  );

  i2cm_pads u_pads (
    .seg(seg), .phase(phase), .bitn(bitn), .txbit(txbit), .mack(mack),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic nack_err,
  input logic q_tick,
  input logic accept,
  input logic idle,
  input logic start_win,
  input logic stop_win
);
  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!scl_oe && !sda_oe));

  a_r2_scl_on_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $past(q_tick));

  a_r4_fall_is_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe) && !scl_oe && !$past(scl_oe)) |-> start_win);

  a_r4_rise_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!sda_oe && $past(sda_oe) && !scl_oe && !$past(scl_oe)) |-> stop_win);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);

  a_r10_nack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle) && !$past(accept)) |-> $stable(nack_err));
endmodule

bind i2c_regxfer_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .nack_err(nack_err), .q_tick(q_tick), .accept(accept),
  .idle(idle), .start_win(start_win), .stop_win(stop_win)
);

// File: tb/i2c_regxfer_master_tb.sv
`timescale 1ns/1ps
module i2c_regxfer_master_tb;
  localparam int QC = 4;
  localparam int NB = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [6:0]    cmd_dev = '0;
  logic [7:0]    cmd_reg = '0;
  logic          cmd_rd = 1'b0;
  logic [8*NB-1:0] cmd_wdata = '0;
  logic [8*NB-1:0] rd_data;
  logic          done, nack_err, scl_in, sda_in, scl_oe, sda_oe;
  logic          slv_low = 1'b0;

  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | slv_low);

  i2c_regxfer_master #(.QUARTER_CYCLES(QC), .DATA_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .done(done), .nack_err(nack_err),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  logic [2:0] plan[$];   // {scl pulled, sda pulled by master, sda pulled by target}

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(bit sl, bit dl, bit tv);
    plan.push_back({sl, dl, tv});
  endtask
  task automatic p_start; put(0,0,0); put(0,1,0); put(0,1,0); put(1,1,0); endtask
  task automatic p_rst;   put(1,0,0); put(0,0,0); put(0,1,0); put(1,1,0); endtask
  task automatic p_stop;  put(1,1,0); put(0,1,0); put(0,0,0); put(0,0,0); endtask
  task automatic p_bit(bit dl, bit tv);
    put(1,dl,tv); put(0,dl,tv); put(0,dl,tv); put(1,dl,tv);
  endtask
  task automatic p_wbyte(logic [7:0] b, bit tgt_ack);
    for (int i = 7; i >= 0; i--) p_bit(!b[i], 1'b0);
    p_bit(1'b0, tgt_ack);
  endtask
  task automatic p_rbyte(logic [7:0] b, bit m_ack);
    for (int i = 7; i >= 0; i--) p_bit(1'b0, !b[i]);
    p_bit(m_ack, 1'b0);
  endtask

  // nack_at: index of the sent byte the target refuses (-1 = none).
  task automatic run(string req, logic [6:0] dev, logic [7:0] rg, bit rd,
                     logic [8*NB-1:0] wd, logic [8*NB-1:0] tsend,
                     int nack_at, bit meddle);
    bit cut;
    cut = 0;
    plan.delete();
    p_start();
    p_wbyte({dev, 1'b0}, nack_at != 0);
    if (nack_at == 0) cut = 1;
    if (!cut) begin
      p_wbyte(rg, nack_at != 1);
      if (nack_at == 1) cut = 1;
    end
    if (!cut && !rd) begin
      for (int j = 0; j < NB; j++) begin
        if (!cut) begin
          p_wbyte(wd[8*j +: 8], nack_at != 2 + j);
          if (nack_at == 2 + j) cut = 1;
        end
      end
    end else if (!cut && rd) begin
      p_rst();
      p_wbyte({dev, 1'b1}, nack_at != 2);
      if (nack_at == 2) cut = 1;
      if (!cut)
        for (int j = 0; j < NB; j++) p_rbyte(tsend[8*j +: 8], j != NB - 1);
    end
    p_stop();

    @(negedge clk);
    cmd_dev = dev; cmd_reg = rg; cmd_rd = rd; cmd_wdata = wd; cmd_valid = 1'b1;
    @(posedge clk);
    for (int q = 0; q < plan.size(); q++) begin
      for (int c = 0; c < QC; c++) begin
        @(negedge clk);
        if (c == 0) begin
          slv_low = plan[q][0];
          if (!meddle && q == 0) cmd_valid = 1'b0;
          if (meddle && q == 0) begin
            cmd_dev = ~dev; cmd_reg = ~rg; cmd_rd = ~rd; cmd_wdata = ~wd;
          end
          if (meddle && q == 12) cmd_valid = 1'b0;
        end
        check(scl_oe == plan[q][2], {req, " R2 R3 R4 R5"}, $sformatf("scl_oe q%0d", q), scl_oe, plan[q][2]);
        check(sda_oe == plan[q][1], {req, " R2 R3 R4 R5"}, $sformatf("sda_oe q%0d", q), sda_oe, plan[q][1]);
        check(done == 1'b0, "R10", "early done", done, 0);
      end
    end
    slv_low = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R10", "done pulse", done, 1);
    check(nack_err == (nack_at >= 0), "R9", "nack flag", nack_err, nack_at >= 0);
    if (rd && nack_at < 0) check(rd_data == tsend, "R8", "read bytes", rd_data, tsend);
    check(!scl_oe && !sda_oe, "R1", "released after stop", {scl_oe, sda_oe}, 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", done, 0);
    check(nack_err == (nack_at >= 0), "R10", "nack hold", nack_err, nack_at >= 0);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!scl_oe && !sda_oe && !done, "R1", "reset state", {scl_oe, sda_oe, done}, 0);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(!scl_oe && !sda_oe && !done && !nack_err, "R1", "idle lines",
            {scl_oe, sda_oe, done, nack_err}, 0);
    end
    // R6: plain write of two bytes
    run("R6", 7'h50, 8'h1A, 1'b0, 16'h3CA5, 16'h0000, -1, 1'b0);
    // R7 R8: register read, ACK on first byte, NACK on last
    run("R7 R8", 7'h2B, 8'h80, 1'b1, 16'h0000, 16'h5EC3, -1, 1'b0);
    // R9: address refused
    run("R9", 7'h11, 8'h22, 1'b0, 16'h4433, 16'h0000, 0, 1'b0);
    // R9: read-direction address after repeated start refused
    run("R9 R7", 7'h61, 8'h07, 1'b1, 16'h0000, 16'hFFFF, 2, 1'b0);
    // R9: last write byte refused
    run("R9 R6", 7'h33, 8'hF0, 1'b0, 16'h0F81, 16'h0000, 3, 1'b0);
    // R11: command inputs toggled during a read are ignored; nack cleared
    run("R11", 7'h45, 8'h5A, 1'b1, 16'h1234, 16'h6996, -1, 1'b1);
    // R5 R8: boundary address and data values
    run("R5 R8", 7'h7F, 8'h00, 1'b1, 16'h0000, 16'h00FF, -1, 1'b0);
    run("R5 R6", 7'h00, 8'hFF, 1'b0, 16'hFF00, 16'h0000, -1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule